// File: doc/BRIEF.md
# X.21 Line Steady-State and Character Sync Monitor

This block sits on the receive side of a serial channel running X.21 call control. Once per bit time, as marked by a bit-clock enable, it takes one received bit. It watches that stream for line states that persist: a run of zeros, a run of ones, or a run of alternating bits. It also watches the CTS line, which carries the I lead on a DTE or the C lead on a DCE, for a change of level that lasts. Any of these conditions must hold for a programmable number of bit times, 16 by default, before it counts.

When a condition is found, the block latches a three-bit status code and raises a level interrupt. The host clears both with an acknowledge pulse. After a data-pattern condition, received characters are withheld from the host until a bit arrives that breaks the detected pattern.

The same bit stream is also searched for a programmable SYN byte. Character sync is declared after one SYN or after two back-to-back SYNs, selected by a mode input. After sync, a character is handed to the host every eight bits. The single-SYN mode also forces two neighbouring receive options off: SYN stripping and special-character detection.

Top module: `x21_line_watch`

## Requirements
- R1: With detection enabled, 16 consecutive received 0 bits latch status code 3'b001.
- R2: With detection enabled, 16 consecutive received 1 bits latch status code 3'b010.
- R3: With detection enabled, 16 consecutive bits that each differ from the bit before latch status code 3'b011.
- R4: CTS passes through a two-flop synchroniser. Its reference level resets to 1. A synchronised level that differs from the reference for 16 consecutive bit times latches status code 3'b100 and becomes the new reference. A shorter excursion latches nothing.
- R5: A run of 15 bits latches nothing, and a bit that breaks the tracked pattern restarts its count.
- R6: The interrupt output is high exactly while the status is nonzero. A latched status keeps its first code until the clear input is pulsed. A detection in the same cycle as a clear wins. Among simultaneous detections the priority is zeros, ones, alternating, then CTS.
- R7: After a data-pattern detection, no character reaches the host, including any character that completes on the detecting bit. Delivery resumes with the character that holds the first bit breaking the pattern.
- R8: The received bit is shifted into an 8-bit register, with the first bit of a byte ending up in the MSB. That register is compared with the SYN byte on every bit. With single-SYN mode at 1, one match declares character sync. With single-SYN mode at 0, a second match exactly 8 bits after the first is needed; any other byte returns the search to hunting.
- R9: After sync, every eighth bit completes a character. The block then gives a one-cycle valid pulse, with the byte on the data output (first received bit in the MSB). Sync holds until reset.
- R10: While single-SYN mode is 1, the effective SYN-strip and special-character-detect outputs are 0. Otherwise they follow their request inputs.
- R11: With detection disabled, no status is latched, the run counts are cleared, and characters are not withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | One-cycle strobe per received bit |
| rx_bit | input | 1 | Received data bit |
| cts_line | input | 1 | Asynchronous CTS level |
| det_en | input | 1 | Steady-state detection enable |
| one_syn | input | 1 | 1: one SYN for sync, 0: two |
| syn_char | input | 8 | SYN byte value |
| strip_req | input | 1 | Requested SYN stripping |
| spc_req | input | 1 | Requested special-character detect |
| clr_stat | input | 1 | Status acknowledge pulse |
| exc_irq | output | 1 | Receive exception interrupt |
| stat_code | output | 3 | Latched condition code |
| char_sync | output | 1 | Character sync achieved |
| host_valid | output | 1 | Character valid pulse |
| host_data | output | 8 | Character to host |
| strip_on | output | 1 | Effective SYN stripping |
| spc_on | output | 1 | Effective special-character detect |

## Verification
Runs of zeros, ones and alternating bits are each driven for 15 and for 16 bits. This separates the threshold from an off-by-one error, and also shows that each pattern gives its own code. A broken run and a short CTS excursion show that counts restart. A latched code followed by a second pattern shows that status holds. Every byte value 0 to 255 is sent after sync to check character framing and bit order. Zero runs spanning several characters, followed by a breaking byte, show which characters are withheld. SYN sequences with and without a foreign byte between them separate one-SYN from two-SYN behaviour.

// File: rtl/x21_line_watch.sv
module x21_line_watch #(
  parameter int RUN_LEN = 16,
  parameter int CHAR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              cts_line,
  input  logic              det_en,
  input  logic              one_syn,
  input  logic [CHAR_W-1:0] syn_char,
  input  logic              strip_req,
  input  logic              spc_req,
  input  logic              clr_stat,
  output logic              exc_irq,
  output logic [2:0]        stat_code,
  output logic              char_sync,
  output logic              host_valid,
  output logic [CHAR_W-1:0] host_data,
  output logic              strip_on,
  output logic              spc_on
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam int BW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);
  localparam logic [BW-1:0] LAST_BIT = BW'(CHAR_W - 1);

  logic              cts_m, cts_s, cts_ref;
  logic [CHAR_W-1:0] sr;
  logic [CW-1:0]     z_run, o_run, a_run, c_run;
  logic              gate;
  logic [1:0]        gate_pat;
  logic [2:0]        stat;
  logic              have_one;
  logic [BW-1:0]     bcnt;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] x);
    return (x == RUN_MAX) ? x : x + 1'b1;
  endfunction

  logic [CHAR_W-1:0] sr_n;
  logic [CW-1:0]     z_n, o_n, a_n, c_n;
  logic              hit_z, hit_o, hit_a, hit_c, upd, brk, gate_n;
  logic [2:0]        code_n;
  logic              match, boundary;

  assign sr_n  = {sr[CHAR_W-2:0], rx_bit};
  assign z_n   = rx_bit ? '0 : bump(z_run);
  assign o_n   = rx_bit ? bump(o_run) : '0;
  assign a_n   = (a_run == '0 || rx_bit != sr[0]) ? bump(a_run) : CW'(1);
  assign c_n   = (cts_s != cts_ref) ? bump(c_run) : '0;
  assign upd   = bit_en && det_en;
  assign hit_z = upd && z_n == RUN_MAX && z_run != RUN_MAX;
  assign hit_o = upd && o_n == RUN_MAX && o_run != RUN_MAX;
  assign hit_a = upd && a_n == RUN_MAX && a_run != RUN_MAX;
  assign hit_c = upd && c_n == RUN_MAX;
  assign code_n = hit_z ? 3'd1 : hit_o ? 3'd2 : hit_a ? 3'd3 : hit_c ? 3'd4 : 3'd0;

  always_comb begin
    case (gate_pat)
      2'd1:    brk = rx_bit;
      2'd2:    brk = !rx_bit;
      default: brk = (rx_bit == sr[0]);
    endcase
    if (!det_en)                     gate_n = 1'b0;
    else if (!bit_en)                gate_n = gate;
    else if (hit_z || hit_o || hit_a) gate_n = 1'b1;
    else if (gate && brk)            gate_n = 1'b0;
    else                             gate_n = gate;
  end

  assign match    = (sr_n == syn_char);
  assign boundary = char_sync && bcnt == LAST_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_m   <= 1'b1;
      cts_s   <= 1'b1;
    end else begin
      cts_m   <= cts_line;
      cts_s   <= cts_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_run   <= '0;
      o_run   <= '0;
      a_run   <= '0;
      c_run   <= '0;
      cts_ref <= 1'b1;
      gate    <= 1'b0;
      gate_pat <= 2'd0;
    end else begin
      gate <= gate_n;
      if (!det_en) begin
        z_run <= '0;
        o_run <= '0;
        a_run <= '0;
        c_run <= '0;
      end else if (bit_en) begin
        z_run <= z_n;
        o_run <= o_n;
        a_run <= a_n;
        if (hit_c) begin
          c_run   <= '0;
          cts_ref <= cts_s;
        end else begin
          c_run   <= c_n;
        end
        if (hit_z)      gate_pat <= 2'd1;
        else if (hit_o) gate_pat <= 2'd2;
        else if (hit_a) gate_pat <= 2'd3;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       stat <= 3'd0;
    else if (code_n != 3'd0 && (stat == 3'd0 || clr_stat)) stat <= code_n;
    else if (clr_stat)                                stat <= 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      char_sync  <= 1'b0;
      have_one   <= 1'b0;
      bcnt       <= '0;
      host_valid <= 1'b0;
      host_data  <= '0;
    end else begin
      host_valid <= 1'b0;
      if (bit_en) begin
        sr <= sr_n;
        if (char_sync) begin
          bcnt <= boundary ? '0 : bcnt + 1'b1;
          if (boundary && !gate_n) begin
            host_valid <= 1'b1;
            host_data  <= sr_n;
          end
        end else if (have_one) begin
          if (bcnt == LAST_BIT) begin
            bcnt     <= '0;
            have_one <= 1'b0;
            if (match) char_sync <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else if (match) begin
          bcnt <= '0;
          if (one_syn) char_sync <= 1'b1;
          else         have_one  <= 1'b1;
        end
      end
    end
  end

  assign stat_code = stat;
  assign exc_irq   = (stat != 3'd0);
  assign strip_on  = strip_req && !one_syn;
  assign spc_on    = spc_req && !one_syn;
endmodule

module x21_line_watch_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              det_en,
  input logic              clr_stat,
  input logic [2:0]        stat_code,
  input logic              char_sync,
  input logic              host_valid
);
  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code != 3'd0 && !clr_stat) |=> $stable(stat_code));
  // R11
  no_det_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && stat_code == 3'd0) |=> stat_code == 3'd0);
  // R9
  sync_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(char_sync));
  // R9
  valid_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> char_sync);
  // R9
  valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> $past(bit_en));
  // R5
  stat_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code != 3'd0 && $past(stat_code) == 3'd0) |-> $past(bit_en));
endmodule

bind x21_line_watch x21_line_watch_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .det_en(det_en),
  .clr_stat(clr_stat), .stat_code(stat_code), .char_sync(char_sync),
  .host_valid(host_valid)
);

// File: tb/sim_x21_line_watch.sv
module sim_x21_line_watch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, rx_bit = 0, cts_line = 1, det_en = 0, one_syn = 0;
  logic [7:0] syn_char = 8'h16;
  logic strip_req = 0, spc_req = 0, clr_stat = 0;
  logic exc_irq, char_sync, host_valid, strip_on, spc_on;
  logic [2:0] stat_code;
  logic [7:0] host_data;

  int errors = 0, checks = 0, nvalid = 0;
  logic got_v;
  logic [7:0] got_d;

  always #2 clk = ~clk;

  x21_line_watch u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .cts_line(cts_line), .det_en(det_en), .one_syn(one_syn),
    .syn_char(syn_char), .strip_req(strip_req), .spc_req(spc_req),
    .clr_stat(clr_stat), .exc_irq(exc_irq), .stat_code(stat_code),
    .char_sync(char_sync), .host_valid(host_valid), .host_data(host_data),
    .strip_on(strip_on), .spc_on(spc_on)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic den, input logic osyn);
    @(negedge clk);
    rst_n = 0; det_en = den; one_syn = osyn; cts_line = 1; bit_en = 0; clr_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b; bit_en = 1;
    @(negedge clk);
    bit_en = 0;
    got_v = host_valid; got_d = host_data;
    if (host_valid) nvalid++;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_stat = 1;
    @(negedge clk); clr_stat = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1, 0);
    check("R6 reset stat", stat_code, 0);
    check("R6 reset irq", exc_irq, 0);
    check("R9 reset sync", char_sync, 0);
    check("R9 reset valid", host_valid, 0);

    // R1 R2 R3 R5: lengths 15 and 16 for each pattern
    for (int p = 0; p < 3; p++) begin
      for (int len = 15; len <= 16; len++) begin
        do_reset(1, 0);
        for (int i = 0; i < len; i++)
          send_bit(p == 0 ? 1'b0 : p == 1 ? 1'b1 : 1'(i % 2));
        check(p == 0 ? "R1 zeros" : p == 1 ? "R2 ones" : "R3 alt",
              stat_code, len == 16 ? p + 1 : 0);
        check("R6 irq level", exc_irq, len == 16 ? 1 : 0);
      end
    end

    // R6: hold first code, then clear
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    check("R6 hold", stat_code, 3);
    pulse_clr();
    check("R6 clear stat", stat_code, 0);
    check("R6 clear irq", exc_irq, 0);

    // R5: break restarts count
    do_reset(1, 0);
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 0; i < 15; i++) send_bit(1'b0);
    check("R5 restart", stat_code, 0);
    send_bit(1'b0);
    check("R5 after restart", stat_code, 1);

    // R11: disabled
    do_reset(0, 0);
    for (int i = 0; i < 40; i++) send_bit(1'b0);
    check("R11 disabled", stat_code, 0);

    // R4: CTS change, short glitch then long
    do_reset(1, 0);
    cts_line = 0; repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    cts_line = 1; repeat (3) @(negedge clk);
    send_bit(1'b0); send_bit(1'b0);
    cts_line = 0; repeat (3) @(negedge clk);
    for (int i = 0; i < 15; i++) send_bit((i % 3) == 0);
    check("R4 short", stat_code, 0);
    send_bit(1'b1);
    check("R4 cts change", stat_code, 4);
    pulse_clr();
    for (int i = 0; i < 15; i++) send_bit((i % 3) == 0);
    check("R4 new reference", stat_code, 0);

    // R8: two-SYN mode
    do_reset(0, 0);
    send_byte(8'h16);
    check("R8 one of two", char_sync, 0);
    send_byte(8'h00);
    send_byte(8'h16);
    check("R8 not consecutive", char_sync, 0);
    send_byte(8'h16);
    check("R8 two syn", char_sync, 1);

    // R8 R9: one-SYN mode, all byte values
    do_reset(0, 1);
    send_byte(8'h16);
    check("R8 one syn", char_sync, 1);
    for (int v = 0; v < 256; v++) begin
      nvalid = 0;
      send_byte(8'(v));
      check("R9 count", nvalid, 1);
      check("R9 data", got_d, v);
    end

    // R7: gating
    do_reset(1, 1);
    send_byte(8'h16);
    nvalid = 0;
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    check("R7 withheld", nvalid, 1);
    check("R7 stat", stat_code, 1);
    nvalid = 0;
    send_byte(8'h80);
    check("R7 resume count", nvalid, 1);
    check("R7 resume data", got_d, 8'h80);

    // R10
    strip_req = 1; spc_req = 1; one_syn = 1; #1;
    check("R10 strip off", strip_on, 0);
    check("R10 spc off", spc_on, 0);
    one_syn = 0; #1;
    check("R10 strip on", strip_on, 1);
    check("R10 spc on", spc_on, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule